// File: doc/BRIEF.md
# Two-wire serial debug target engine

This block sits on the target side of a two-wire debug link and runs entirely on the debug clock. The host shifts in an eight-bit request header over a single bidirectional data pin. The engine checks the header's framing and parity, turns the pin around, and answers with a three-bit acknowledge. When the acknowledge is OK, a 32-bit payload follows in the direction the header requested. Every change of pin direction costs exactly one idle turnaround cycle, and the engine drives a pad output-enable so that the pad cell can tristate the pin.

Behind the engine is a small register-access port. It carries a debug/access port select bit, a two-bit register address, single-cycle read and write strobes, write data, and read data. Two level status inputs, wait and fault, set the acknowledge. If the host holds the line high for long enough, any transfer in progress is abandoned and the engine returns to its reset state.

Top module: `swd_target`

## Requirements
- R1: After reset the pin is released (`dio_oe_o`=0) and both strobes are low. The engine then waits for one low sample before it will accept a start bit.
- R2: The header is sampled bit by bit in this order: start (must be 1), port select (1 = access port), direction (1 = read), address bit 0, address bit 1, parity, stop (must be 0), park (must be 1). The parity bit must equal the XOR of the port select, direction and both address bits. A header that breaks any of these rules gets no acknowledge, the pin stays released, and the engine goes back to searching for a start bit.
- R3: After a valid header there is one released cycle, then three driven acknowledge bits. The bits appear on the line as 1,0,0 for OK, 0,1,0 for WAIT and 0,0,1 for FAULT. The acknowledge is taken from the status inputs in the cycle the park bit is sampled, and fault wins over wait.
- R4: On an OK read, `reg_rd_o` pulses once at header completion. The 32 read bits follow the last acknowledge bit directly, LSB first, then one even-parity bit. The pin is released for one cycle after that.
- R5: On an OK write, one released cycle follows the acknowledge. The engine then samples 32 data bits LSB first and one even-parity bit. If the parity matches, `reg_wr_o` pulses for one cycle, with `reg_wdata_o`, `reg_ap_o` and `reg_addr_o` holding the transfer's values.
- R6: A write whose data parity is wrong produces no write strobe, and the addressed register keeps its old value.
- R7: A WAIT or FAULT acknowledge ends the transfer. There is no data phase and no strobe, and the pin is released in the cycle after the third acknowledge bit.
- R8: Once 51 consecutive high samples have been taken while the pin is released, the engine enters its reset state from any state. A start bit is only accepted after a later low sample.
- R9: `reg_rd_o` and `reg_wr_o` are never high together, and each is high for a single cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Debug clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dio_i | input | 1 | Data pin as seen from the pad |
| dio_o | output | 1 | Data driven to the pad |
| dio_oe_o | output | 1 | Pad output enable |
| reg_ap_o | output | 1 | Port select of current transfer (1 = access port) |
| reg_addr_o | output | 2 | Register address of current transfer |
| reg_rd_o | output | 1 | Single-cycle read strobe |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | DATA_W | Write data, valid with reg_wr_o |
| reg_rdata_i | input | DATA_W | Read data, sampled in the cycle after reg_rd_o rises |
| reg_wait_i | input | 1 | Port busy: answer WAIT |
| reg_fault_i | input | 1 | Sticky error set: answer FAULT |

## Verification
A host model in the bench first writes all eight port/address combinations with arithmetically spread values, then reads each one back. Any mix-up between port select and address bits, or between bit order and parity, shows up as a wrong word. All-ones and single-one payloads exercise both values of the data parity bit. The headers that must be rejected break parity, stop and park one at a time, which separates each framing rule from the others. Wait, fault and both together tell the acknowledge priority apart. A corrupted write parity followed by a read-back shows that the write was not committed. The long run of ones is sent from idle and followed either by a single low bit or by none, which distinguishes a real line reset from plain header resynchronisation.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_HDR, ST_TRN1, ST_ACK,
    ST_RDATA, ST_TRNW, ST_WDATA, ST_TRN2
  } swd_state_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam int unsigned HDR_W    = 8;
endpackage

// File: rtl/swd_parity.sv
module swd_parity #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] d_i,
  output logic         p_o
);
  assign p_o = ^d_i;
endmodule

// File: rtl/swd_hdr_decode.sv
module swd_hdr_decode
  import swd_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  output logic             valid_o,
  output logic             ap_o,
  output logic             rnw_o,
  output logic [1:0]       addr_o
);
  logic par;

  swd_parity #(.W(4)) u_par (
    .d_i (hdr_i[4:1]),
    .p_o (par)
  );

  // bit0 start, bit5 parity, bit6 stop, bit7 park
  assign valid_o = hdr_i[0] & ~hdr_i[6] & hdr_i[7] & (hdr_i[5] == par);
  assign ap_o    = hdr_i[1];
  assign rnw_o   = hdr_i[2];
  assign addr_o  = hdr_i[4:3];
endmodule

// File: rtl/swd_line_reset.sv
module swd_line_reset #(
  parameter int unsigned LRST_CYC = 51
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic lrst_o
);
  localparam int unsigned CW = $clog2(LRST_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || !bit_i)     cnt_q <= '0;
    else if (cnt_q != CW'(LRST_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign lrst_o = en_i & bit_i & (cnt_q >= CW'(LRST_CYC - 1));
endmodule

// File: rtl/swd_shreg.sv
module swd_shreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (load_i)   q_o <= load_val_i;
    else if (shift_i)  q_o <= {sin_i, q_o[W-1:1]};
  end
endmodule

// File: rtl/swd_target.sv
module swd_target
  import swd_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LRST_CYC = 51
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dio_i,
  output logic              dio_o,
  output logic              dio_oe_o,
  output logic              reg_ap_o,
  output logic [1:0]        reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_wait_i,
  input  logic              reg_fault_i
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 2);

  swd_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [5:0]        hdr_q;
  logic              ap_q, rnw_q, rd_q, wr_q, dout_q, oe_q, rpar_q;
  logic [1:0]        addr_q, ack_sh_q;
  logic [2:0]        ack_q, ack_sel;
  logic [HDR_W-1:0]  hdr_full;
  logic              hdr_ok, hdr_ap, hdr_rnw;
  logic [1:0]        hdr_addr;
  logic              lrst, rd_go, sh_load, sh_shift;
  logic [DATA_W-1:0] sh_q;
  logic              rdata_par, wdata_par;

  assign hdr_full = {dio_i, hdr_q, 1'b1};

  swd_hdr_decode u_hdr (
    .hdr_i   (hdr_full),
    .valid_o (hdr_ok),
    .ap_o    (hdr_ap),
    .rnw_o   (hdr_rnw),
    .addr_o  (hdr_addr)
  );

  swd_line_reset #(.LRST_CYC(LRST_CYC)) u_lrst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~oe_q),
    .bit_i  (dio_i),
    .lrst_o (lrst)
  );

  swd_parity #(.W(DATA_W)) u_rpar (.d_i(reg_rdata_i), .p_o(rdata_par));
  swd_parity #(.W(DATA_W)) u_wpar (.d_i(sh_q),        .p_o(wdata_par));

  assign rd_go    = (ack_q == ACK_OK) && rnw_q;
  assign sh_load  = !lrst && (state_q == ST_TRN1) && rd_q;
  assign sh_shift = !lrst && (((state_q == ST_ACK) && (cnt_q == CNT_W'(2)) && rd_go) ||
                              ((state_q == ST_RDATA) && (cnt_q < CNT_W'(DATA_W))) ||
                              ((state_q == ST_WDATA) && (cnt_q < CNT_W'(DATA_W))));

  swd_shreg #(.W(DATA_W)) u_sh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_val_i (reg_rdata_i),
    .shift_i    (sh_shift),
    .sin_i      (dio_i),
    .q_o        (sh_q)
  );

  // fault outranks wait
  always_comb begin
    if (reg_fault_i)     ack_sel = ACK_FAULT;
    else if (reg_wait_i) ack_sel = ACK_WAIT;
    else                 ack_sel = ACK_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RESET;
      cnt_q    <= '0;
      hdr_q    <= '0;
      ap_q     <= 1'b0;
      rnw_q    <= 1'b0;
      addr_q   <= '0;
      ack_q    <= ACK_OK;
      ack_sh_q <= '0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      rpar_q   <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      if (lrst) begin
        state_q <= ST_RESET;
        oe_q    <= 1'b0;
        dout_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RESET: if (!dio_i) state_q <= ST_IDLE;
          ST_IDLE: begin
            if (dio_i) begin
              state_q <= ST_HDR;
              cnt_q   <= '0;
            end
          end
          ST_HDR: begin
            hdr_q <= {dio_i, hdr_q[5:1]};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(HDR_W - 2)) begin
              if (hdr_ok) begin
                ap_q    <= hdr_ap;
                rnw_q   <= hdr_rnw;
                addr_q  <= hdr_addr;
                ack_q   <= ack_sel;
                rd_q    <= hdr_rnw && (ack_sel == ACK_OK);
                state_q <= ST_TRN1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_TRN1: begin
            oe_q     <= 1'b1;
            dout_q   <= ack_q[0];
            ack_sh_q <= ack_q[2:1];
            cnt_q    <= '0;
            if (rd_q) rpar_q <= rdata_par;
            state_q  <= ST_ACK;
          end
          ST_ACK: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q < CNT_W'(2)) begin
              dout_q   <= ack_sh_q[0];
              ack_sh_q <= {1'b0, ack_sh_q[1]};
            end else if (rd_go) begin
              dout_q  <= sh_q[0];
              cnt_q   <= CNT_W'(1);
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              dout_q  <= 1'b0;
              state_q <= (ack_q == ACK_OK) ? ST_TRNW : ST_TRN2;
            end
          end
          ST_RDATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q < CNT_W'(DATA_W)) begin
              dout_q <= sh_q[0];
            end else if (cnt_q == CNT_W'(DATA_W)) begin
              dout_q <= rpar_q;
            end else begin
              oe_q    <= 1'b0;
              dout_q  <= 1'b0;
              state_q <= ST_TRN2;
            end
          end
          ST_TRNW: begin
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
          ST_WDATA: begin
            if (cnt_q < CNT_W'(DATA_W)) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              wr_q    <= (dio_i == wdata_par);
              state_q <= ST_IDLE;
            end
          end
          ST_TRN2: state_q <= ST_IDLE;
          default: state_q <= ST_RESET;
        endcase
      end
    end
  end

  assign dio_o       = dout_q;
  assign dio_oe_o    = oe_q;
  assign reg_ap_o    = ap_q;
  assign reg_addr_o  = addr_q;
  assign reg_rd_o    = rd_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = sh_q;
endmodule

// File: rtl/swd_target_chk.sv
module swd_target_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic dio_oe_o,
  input logic reg_rd_o,
  input logic reg_wr_o
);
  localparam int unsigned RW = $clog2(DATA_W + 8);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (dio_oe_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_RD_THEN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> dio_oe_o); // R4
  AST_DRIVE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dio_oe_o) |-> (run_q == RW'(3) || run_q == RW'(DATA_W + 4))); // R7
  AST_TRN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dio_oe_o) |=> !dio_oe_o); // R3
  AST_WR_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !dio_oe_o); // R5
  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o)); // R9
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o); // R9
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o); // R9
endmodule

bind swd_target swd_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dio_oe_o (dio_oe_o),
  .reg_rd_o (reg_rd_o),
  .reg_wr_o (reg_wr_o)
);

// File: tb/swd_target_bench.sv
`timescale 1ns/1ps
module swd_target_bench;
  localparam int DW = 32;
  localparam logic [2:0] OK = 3'b001, WT = 3'b010, FT = 3'b100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic host_drv = 1'b0;
  logic dio_i, dio_o, dio_oe_o;
  logic reg_ap_o, reg_rd_o, reg_wr_o;
  logic [1:0] reg_addr_o;
  logic [DW-1:0] reg_wdata_o, reg_rdata_i;
  logic reg_wait_i = 1'b0, reg_fault_i = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0, both_seen = 1'b0;
  logic [DW-1:0] port_mem [8];
  logic [DW-1:0] exp_mem [8];

  always #10 clk_i = ~clk_i;

  assign dio_i = dio_oe_o ? dio_o : host_drv;
  assign reg_rdata_i = port_mem[{reg_ap_o, reg_addr_o}];

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) port_mem[i] <= 32'hA5A5_0000 ^ (32'h1111_1111 * i);
    end else if (reg_wr_o) begin
      port_mem[{reg_ap_o, reg_addr_o}] <= reg_wdata_o;
    end
    if (reg_rd_o && reg_wr_o) both_seen <= 1'b1;
  end

  swd_target u_swd_target (
    .clk_i(clk_i), .rst_ni(rst_ni), .dio_i(dio_i), .dio_o(dio_o), .dio_oe_o(dio_oe_o),
    .reg_ap_o(reg_ap_o), .reg_addr_o(reg_addr_o), .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i),
    .reg_wait_i(reg_wait_i), .reg_fault_i(reg_fault_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    host_drv = b;
  endtask

  function automatic logic [7:0] hdr_bits(input bit ap, input bit rnw, input logic [1:0] a);
    return {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic xfer(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd,
                      input bit bad_par, input logic [2:0] exp_ack, input string tag);
    logic [7:0] h;
    logic [2:0] ack;
    logic [31:0] rv;
    logic pb;
    bit drv_ok;
    int idx;
    idx = {ap, a};
    h = hdr_bits(ap, rnw, a);
    for (int i = 0; i < 8; i++) send_bit(h[i]);
    @(negedge clk_i);
    host_drv = 1'b0;
    chk(!dio_oe_o, {tag, " R3 turnaround before ack"}, dio_oe_o, 0);
    chk(reg_rd_o == (rnw && exp_ack == OK), {tag, " R4 read strobe"}, reg_rd_o, rnw && exp_ack == OK);
    drv_ok = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      ack[i] = dio_o;
      drv_ok &= dio_oe_o;
      if (i == 0) chk(!reg_rd_o, {tag, " R9 read strobe single cycle"}, reg_rd_o, 0);
    end
    chk(drv_ok && ack == exp_ack, {tag, " R3 acknowledge"}, {drv_ok, ack}, {1'b1, exp_ack});
    if (exp_ack != OK) begin
      @(negedge clk_i);
      chk(!dio_oe_o && !reg_wr_o, {tag, " R7 released, no data phase"}, {dio_oe_o, reg_wr_o}, 0);
    end else if (rnw) begin
      drv_ok = 1'b1;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk_i);
        rv[i] = dio_o;
        drv_ok &= dio_oe_o;
      end
      @(negedge clk_i);
      pb = dio_o;
      drv_ok &= dio_oe_o;
      chk(drv_ok && rv == exp_mem[idx], {tag, " R4 read data"}, rv, exp_mem[idx]);
      chk(pb == ^exp_mem[idx], {tag, " R4 read parity"}, pb, ^exp_mem[idx]);
      @(negedge clk_i);
      chk(!dio_oe_o, {tag, " R4 turnaround after data"}, dio_oe_o, 0);
    end else begin
      @(negedge clk_i);
      chk(!dio_oe_o, {tag, " R5 turnaround before write data"}, dio_oe_o, 0);
      for (int i = 0; i < 32; i++) send_bit(wd[i]);
      send_bit((^wd) ^ bad_par);
      @(negedge clk_i);
      host_drv = 1'b0;
      if (bad_par) begin
        chk(!reg_wr_o, {tag, " R6 no commit on bad parity"}, reg_wr_o, 0);
      end else begin
        chk(reg_wr_o && reg_wdata_o == wd && {reg_ap_o, reg_addr_o} == 3'(idx),
            {tag, " R5 write commit"}, reg_wdata_o, wd);
        exp_mem[idx] = wd;
      end
    end
    idle(2);
  endtask

  task automatic bad_hdr(input logic [7:0] h, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 8; i++) send_bit(h[i]);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      host_drv = 1'b0;
      seen |= dio_oe_o | reg_rd_o | reg_wr_o;
    end
    chk(!seen, {tag, " no acknowledge"}, seen, 0);
    idle(2);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_mem[i] = 32'hA5A5_0000 ^ (32'h1111_1111 * i);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!dio_oe_o && !reg_rd_o && !reg_wr_o, "R1 reset state", {dio_oe_o, reg_rd_o, reg_wr_o}, 0);
    idle(2);

    // sweep all port/address combinations
    for (int i = 0; i < 8; i++)
      xfer(i[2], 1'b0, i[1:0], 32'h9E37_79B9 * (i + 1), 1'b0, OK, "R2 sweep write");
    for (int i = 0; i < 8; i++)
      xfer(i[2], 1'b1, i[1:0], '0, 1'b0, OK, "R2 sweep read");

    // both parity values of the payload
    xfer(1'b0, 1'b0, 2'd3, 32'hFFFF_FFFF, 1'b0, OK, "R5 all ones");
    xfer(1'b0, 1'b1, 2'd3, '0, 1'b0, OK, "R4 all ones");
    xfer(1'b1, 1'b0, 2'd0, 32'h0000_0001, 1'b0, OK, "R5 single one");
    xfer(1'b1, 1'b1, 2'd0, '0, 1'b0, OK, "R4 single one");

    // header framing rejections
    bad_hdr(hdr_bits(1'b1, 1'b1, 2'd2) ^ 8'h20, "R2 bad parity");
    bad_hdr(hdr_bits(1'b0, 1'b1, 2'd1) ^ 8'h40, "R2 bad stop");
    bad_hdr(hdr_bits(1'b1, 1'b0, 2'd1) ^ 8'h80, "R2 bad park");

    // acknowledge selection
    reg_wait_i = 1'b1;
    xfer(1'b0, 1'b1, 2'd1, '0, 1'b0, WT, "R7 wait read");
    xfer(1'b1, 1'b0, 2'd1, 32'hDEAD_BEEF, 1'b0, WT, "R7 wait write");
    reg_fault_i = 1'b1;
    xfer(1'b0, 1'b1, 2'd2, '0, 1'b0, FT, "R3 fault over wait");
    reg_wait_i = 1'b0;
    xfer(1'b1, 1'b0, 2'd2, 32'h1234_5678, 1'b0, FT, "R7 fault write");
    reg_fault_i = 1'b0;
    xfer(1'b1, 1'b1, 2'd1, '0, 1'b0, OK, "R7 wait write left data");

    // bad write data parity
    xfer(1'b1, 1'b0, 2'd1, 32'h0F0F_3C3C, 1'b1, OK, "R6 bad write parity");
    xfer(1'b1, 1'b1, 2'd1, '0, 1'b0, OK, "R6 readback");

    // line reset from idle, then a single low bit
    for (int i = 0; i < 60; i++) send_bit(1'b1);
    send_bit(1'b0);
    xfer(1'b0, 1'b1, 2'd0, '0, 1'b0, OK, "R8 after line reset");

    // line reset then header without a low bit first
    for (int i = 0; i < 60; i++) send_bit(1'b1);
    bad_hdr(hdr_bits(1'b0, 1'b1, 2'd0), "R8 start needs prior low");
    xfer(1'b0, 1'b1, 2'd2, '0, 1'b0, OK, "R1 recovery read");

    chk(!both_seen, "R9 strobes exclusive", both_seen, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule